// File: doc/BRIEF.md
# Head Retract Sequencing Controller

This block runs the normal head unload of a disc drive. While the drive is loaded and ready it grants seek, recalibrate and write requests. When the drive-ready input drops, it withdraws access at once, requests a reverse constant-velocity slew of the carriage, and latches a retract status bit and an attention bit. It then waits for the carriage-fully-back sense. Carriage-back during the slew cancels a 1667 ms watchdog and turns the positioning servo off. If the watchdog expires first, the servo is turned off as well, and a fault bit is latched.

Once the carriage is parked, a stop request halts the spindle. A stop request on its own is not enough: the carriage must be back, or the timeout fault must be latched. The pack door unlocks only after the spindle reports that it has stopped. The heads stay parked and the door stays unlocked until a head-load request arrives. That request restarts the drive and clears the retract and fault bits. The attention bit is cleared separately, by a clear-status command.

Top module: `head_retract_ctrl`

## Requirements
- R1: After reset, door_unlock is 1 and access_ready, ready_lamp, fault_check_en, slew_rev, servo_en, run_spindle, stat_retract, stat_attn, stat_fault and cmd_go are all 0.
- R2: A load_req while the door is unlocked takes effect at the next clock edge. From then on, access_ready, ready_lamp, fault_check_en, servo_en and run_spindle are 1, and door_unlock, stat_retract and stat_fault are 0.
- R3: If drive_ready is 0 at a clock edge while the drive is loaded, then from that edge access_ready, ready_lamp and fault_check_en are 0, slew_rev is 1, stat_retract is 1 and stat_attn is 1.
- R4: cmd_go[i] equals cmd_req[i] AND access_ready, where bit 0 is seek, bit 1 is recalibrate and bit 2 is write.
- R5: clear_status clears stat_attn at the next edge and leaves stat_retract unchanged. If attention is being set in the same cycle, setting wins.
- R6: carriage_back during the slew ends it at the next edge. From then on slew_rev and servo_en are 0, and run_spindle stays 1.
- R7: The slew watchdog counts tick_1ms pulses only while slewing. On the 1667th tick without carriage_back, the block sets stat_fault and stat_attn and drops slew_rev and servo_en. A carriage_back that coincides with that final tick wins, and no fault is latched.
- R8: With the carriage parked, run_spindle drops at the edge where stop_req is 1 and either carriage_back or stat_fault is 1. A stop_req with neither has no effect.
- R9: door_unlock rises only at the edge after spindle_stopped is seen while the spindle is being stopped. spindle_stopped at any other time has no effect.
- R10: load_req outside the unlocked state has no effect. A return of drive_ready during a retract does not restore access_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_ready | input | 1 | Drive ready; low starts a retract |
| carriage_back | input | 1 | Carriage fully retracted sense |
| stop_req | input | 1 | Stop spindle request |
| spindle_stopped | input | 1 | Spindle braked to rest |
| clear_status | input | 1 | Clear attention command |
| tick_1ms | input | 1 | One-cycle pulse each millisecond |
| load_req | input | 1 | Head load request |
| cmd_req | input | 3 | Seek, recalibrate, write requests |
| access_ready | output | 1 | Heads available for access |
| ready_lamp | output | 1 | Ready indicator drive |
| fault_check_en | output | 1 | AGC and carriage-back fault checking enable |
| slew_rev | output | 1 | Reverse constant-velocity slew request |
| servo_en | output | 1 | Head positioning servo enable |
| run_spindle | output | 1 | Spindle run command |
| door_unlock | output | 1 | Pack door unlock solenoid |
| stat_retract | output | 1 | Retract status bit |
| stat_attn | output | 1 | Attention status bit |
| stat_fault | output | 1 | Retract timeout fault bit |
| cmd_go | output | 3 | Granted seek, recalibrate, write |

## Verification
The hardest case to reach is the watchdog boundary. It needs 1666 uninterrupted ticks in the slew state with carriage_back held low, and then a decision on the very next tick. Random stimulus raises carriage_back far too often to ever get there. So directed phases hold tick_1ms high every cycle and run the slew to exactly 1666 ticks. One run lets the final tick expire; another raises carriage_back in that same cycle. A cycle-by-cycle bench model checks every output in both phases and through a long random phase.

// File: rtl/hrc_pkg.sv
package hrc_pkg;
  typedef enum logic [2:0] {
    ST_OPEN   = 3'd0,
    ST_LOADED = 3'd1,
    ST_SLEW   = 3'd2,
    ST_PARKED = 3'd3,
    ST_BRAKE  = 3'd4
  } hrc_state_e;
endpackage

// File: rtl/hrc_watchdog.sv
module hrc_watchdog #(
  parameter int LIMIT = 1667
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic expire
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expire = run && tick && (cnt_q == LAST);
  assign cnt_en = !run || tick;

  always_comb begin
    cnt_d = cnt_q;
    if (!run)        cnt_d = '0;
    else if (expire) cnt_d = '0;
    else if (tick)   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
  assert_cnt_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt_q == '0));
endmodule

// File: rtl/hrc_seq_fsm.sv
module hrc_seq_fsm
  import hrc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic drive_ready,
  input  logic carriage_back,
  input  logic stop_req,
  input  logic spindle_stopped,
  input  logic load_req,
  input  logic expire,
  input  logic fault_latched,
  output logic access_ready,
  output logic slew_rev,
  output logic servo_en,
  output logic run_spindle,
  output logic door_unlock,
  output logic timer_run,
  output logic retract_evt,
  output logic timeout_evt,
  output logic load_evt
);
  hrc_state_e state_q, state_d;

  assign load_evt    = (state_q == ST_OPEN) && load_req;
  assign retract_evt = (state_q == ST_LOADED) && !drive_ready;
  assign timeout_evt = (state_q == ST_SLEW) && !carriage_back && expire;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OPEN:   if (load_req) state_d = ST_LOADED;
      ST_LOADED: if (!drive_ready) state_d = ST_SLEW;
      ST_SLEW:   if (carriage_back || expire) state_d = ST_PARKED;
      ST_PARKED: if (stop_req && (carriage_back || fault_latched)) state_d = ST_BRAKE;
      ST_BRAKE:  if (spindle_stopped) state_d = ST_OPEN;
      default:   state_d = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_OPEN;
    else        state_q <= state_d;
  end

  assign access_ready = (state_q == ST_LOADED);
  assign slew_rev     = (state_q == ST_SLEW);
  assign timer_run    = (state_q == ST_SLEW);
  assign servo_en     = (state_q == ST_LOADED) || (state_q == ST_SLEW);
  assign run_spindle  = servo_en || (state_q == ST_PARKED);
  assign door_unlock  = (state_q == ST_OPEN);

  assert_door_after_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(door_unlock) |-> $past(spindle_stopped));
  assert_spindle_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(run_spindle) |-> ($past(stop_req) && ($past(carriage_back) || $past(fault_latched))));
  assert_servo_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(servo_en) |-> ($past(carriage_back) || $past(expire)));
  assert_access_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(access_ready) |-> $past(load_req));
endmodule

// File: rtl/hrc_status.sv
module hrc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic retract_evt,
  input  logic timeout_evt,
  input  logic load_evt,
  input  logic clear_status,
  output logic stat_retract,
  output logic stat_attn,
  output logic stat_fault
);
  logic ret_d, attn_d, flt_d;

  always_comb begin
    ret_d = stat_retract;
    if (load_evt)         ret_d = 1'b0;
    else if (retract_evt) ret_d = 1'b1;

    attn_d = stat_attn;
    if (retract_evt || timeout_evt) attn_d = 1'b1;
    else if (clear_status)          attn_d = 1'b0;

    flt_d = stat_fault;
    if (load_evt)         flt_d = 1'b0;
    else if (timeout_evt) flt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_retract <= 1'b0;
      stat_attn    <= 1'b0;
      stat_fault   <= 1'b0;
    end else begin
      stat_retract <= ret_d;
      stat_attn    <= attn_d;
      stat_fault   <= flt_d;
    end
  end

  assert_retract_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_retract) |-> $past(load_evt));
  assert_attn_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat_attn) |-> $past(clear_status));
  assert_fault_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_fault) |-> $past(timeout_evt));
endmodule

// File: rtl/hrc_cmd_gate.sv
module hrc_cmd_gate #(
  parameter int N_CMD = 3
) (
  input  logic             enable,
  input  logic [N_CMD-1:0] req,
  output logic [N_CMD-1:0] go
);
  for (genvar i = 0; i < N_CMD; i++) begin : g_gate
    assign go[i] = req[i] & enable;
  end
endmodule

// File: rtl/head_retract_ctrl.sv
module head_retract_ctrl #(
  parameter int TIMEOUT_TICKS = 1667,
  parameter int N_CMD         = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             drive_ready,
  input  logic             carriage_back,
  input  logic             stop_req,
  input  logic             spindle_stopped,
  input  logic             clear_status,
  input  logic             tick_1ms,
  input  logic             load_req,
  input  logic [N_CMD-1:0] cmd_req,
  output logic             access_ready,
  output logic             ready_lamp,
  output logic             fault_check_en,
  output logic             slew_rev,
  output logic             servo_en,
  output logic             run_spindle,
  output logic             door_unlock,
  output logic             stat_retract,
  output logic             stat_attn,
  output logic             stat_fault,
  output logic [N_CMD-1:0] cmd_go
);
  logic [1:0] rst_sync_q;
  logic       rst_n_i;
  logic       expire, timer_run;
  logic       retract_evt, timeout_evt, load_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_i = rst_sync_q[1];

  hrc_watchdog #(.LIMIT(TIMEOUT_TICKS)) u_wdog (
    .clk(clk), .rst_n(rst_n_i), .run(timer_run), .tick(tick_1ms), .expire(expire)
  );

  hrc_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_i),
    .drive_ready(drive_ready), .carriage_back(carriage_back),
    .stop_req(stop_req), .spindle_stopped(spindle_stopped),
    .load_req(load_req), .expire(expire), .fault_latched(stat_fault),
    .access_ready(access_ready), .slew_rev(slew_rev), .servo_en(servo_en),
    .run_spindle(run_spindle), .door_unlock(door_unlock), .timer_run(timer_run),
    .retract_evt(retract_evt), .timeout_evt(timeout_evt), .load_evt(load_evt)
  );

  hrc_status u_stat (
    .clk(clk), .rst_n(rst_n_i),
    .retract_evt(retract_evt), .timeout_evt(timeout_evt),
    .load_evt(load_evt), .clear_status(clear_status),
    .stat_retract(stat_retract), .stat_attn(stat_attn), .stat_fault(stat_fault)
  );

  hrc_cmd_gate #(.N_CMD(N_CMD)) u_gate (
    .enable(access_ready), .req(cmd_req), .go(cmd_go)
  );

  assign ready_lamp     = access_ready;
  assign fault_check_en = access_ready;

  assert_slew_excl_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    $rose(slew_rev) |-> ($past(access_ready) && !$past(drive_ready)));
endmodule

// File: tb/head_retract_ctrl_bench.sv
module head_retract_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic drive_ready, carriage_back, stop_req, spindle_stopped;
  logic clear_status, tick_1ms, load_req;
  logic [2:0] cmd_req;
  logic access_ready, ready_lamp, fault_check_en, slew_rev, servo_en;
  logic run_spindle, door_unlock, stat_retract, stat_attn, stat_fault;
  logic [2:0] cmd_go;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // model: 0 open, 1 loaded, 2 slew, 3 parked, 4 brake
  int m_st = 0;
  int m_cnt = 0;
  bit m_ret = 0, m_attn = 0, m_flt = 0;

  always #5 clk = ~clk;

  head_retract_ctrl u_head_retract_ctrl (
    .clk(clk), .rst_n(rst_n), .drive_ready(drive_ready), .carriage_back(carriage_back),
    .stop_req(stop_req), .spindle_stopped(spindle_stopped), .clear_status(clear_status),
    .tick_1ms(tick_1ms), .load_req(load_req), .cmd_req(cmd_req),
    .access_ready(access_ready), .ready_lamp(ready_lamp), .fault_check_en(fault_check_en),
    .slew_rev(slew_rev), .servo_en(servo_en), .run_spindle(run_spindle),
    .door_unlock(door_unlock), .stat_retract(stat_retract), .stat_attn(stat_attn),
    .stat_fault(stat_fault), .cmd_go(cmd_go)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit e_access(int st); return st == 1; endfunction
  function automatic bit e_servo(int st);  return st == 1 || st == 2; endfunction
  function automatic bit e_run(int st);    return st == 1 || st == 2 || st == 3; endfunction

  task automatic compare_all();
    chk(access_ready,   e_access(m_st), "R3 access_ready");
    chk(ready_lamp,     e_access(m_st), "R3 ready_lamp");
    chk(fault_check_en, e_access(m_st), "R3 fault_check_en");
    chk(slew_rev,       m_st == 2,      "R6 slew_rev");
    chk(servo_en,       e_servo(m_st),  "R6 servo_en");
    chk(run_spindle,    e_run(m_st),    "R8 run_spindle");
    chk(door_unlock,    m_st == 0,      "R9 door_unlock");
    chk(stat_retract,   m_ret,          "R10 stat_retract");
    chk(stat_attn,      m_attn,         "R5 stat_attn");
    chk(stat_fault,     m_flt,          "R7 stat_fault");
    chk(cmd_go, cmd_req & {3{e_access(m_st)}}, "R4 cmd_go");
  endtask

  task automatic step();
    int  ns = m_st;
    int  nc = m_cnt;
    bit  nr = m_ret, na = m_attn, nf = m_flt;
    bit  set_attn = 0;
    case (m_st)
      0: if (load_req) begin ns = 1; nr = 0; nf = 0; end
      1: if (!drive_ready) begin ns = 2; nr = 1; set_attn = 1; end
      2: if (carriage_back) ns = 3;
         else if (tick_1ms && m_cnt == 1666) begin ns = 3; nf = 1; set_attn = 1; end
         else if (tick_1ms) nc = m_cnt + 1;
      3: if (stop_req && (carriage_back || m_flt)) ns = 4;
      4: if (spindle_stopped) ns = 0;
      default: ns = 0;
    endcase
    if (ns != 2) nc = 0;
    if (set_attn) na = 1;
    else if (clear_status) na = 0;
    @(posedge clk);
    @(negedge clk);
    m_st = ns; m_cnt = nc; m_ret = nr; m_attn = na; m_flt = nf;
    compare_all();
  endtask

  task automatic idle_inputs();
    drive_ready = 1; carriage_back = 0; stop_req = 0; spindle_stopped = 0;
    clear_status = 0; tick_1ms = 0; load_req = 0; cmd_req = 3'b000;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) step();
    // R1 reset state
    chk(door_unlock, 1, "R1 door_unlock after reset");
    chk({access_ready, servo_en, run_spindle, slew_rev}, 0, "R1 drive idle after reset");
    chk({stat_retract, stat_attn, stat_fault}, 0, "R1 status clear after reset");

    // R4 gate closed while unlocked, R9 stray spindle_stopped ignored
    cmd_req = 3'b111; spindle_stopped = 1; step();
    chk(cmd_go, 3'b000, "R4 no grant while unlocked");
    spindle_stopped = 0;

    // R2 load
    load_req = 1; step(); load_req = 0;
    chk({access_ready, servo_en, run_spindle, door_unlock}, 4'b1110, "R2 load takes effect");
    chk(cmd_go, 3'b111, "R4 grants while loaded");
    cmd_req = 3'b101; step();
    chk(cmd_go, 3'b101, "R4 seek and write only");

    // R10 load while loaded ignored
    load_req = 1; step(); load_req = 0;
    chk(access_ready, 1, "R10 load while loaded ignored");

    // R3 + R5 set wins over clear
    drive_ready = 0; clear_status = 1; step();
    chk({access_ready, slew_rev, stat_retract, stat_attn}, 4'b0111, "R3 retract start, R5 set wins");
    chk(cmd_go, 3'b000, "R4 blocked while retracting");

    // R5 clear leaves retract; R10 drive_ready return ignored
    drive_ready = 1; step(); clear_status = 0;
    chk({stat_attn, stat_retract}, 2'b01, "R5 clear attn keeps retract");
    chk(access_ready, 0, "R10 drive_ready return no restore");

    // R10 load and R9 spindle_stopped ignored while slewing; R8 stop w/o cb
    load_req = 1; spindle_stopped = 1; stop_req = 1; step(); step();
    load_req = 0; spindle_stopped = 0;
    chk({slew_rev, door_unlock, run_spindle}, 3'b101, "R10 load ignored during slew");

    // R7 timeout boundary
    tick_1ms = 1; stop_req = 0;
    repeat (1666) step();
    chk({slew_rev, stat_fault}, 2'b10, "R7 still slewing after 1666 ticks");
    step();
    chk({slew_rev, servo_en, stat_fault, stat_attn}, 4'b0011, "R7 timeout at tick 1667");
    chk(run_spindle, 1, "R7 spindle still running after timeout");
    tick_1ms = 0;

    // R8 fault path stop, R9 door
    stop_req = 1; step(); stop_req = 0;
    chk(run_spindle, 0, "R8 stop via fault path");
    step(); step();
    chk(door_unlock, 0, "R9 door held until spindle stops");
    spindle_stopped = 1; step(); spindle_stopped = 0;
    chk(door_unlock, 1, "R9 door unlocks after spindle stop");

    // R2 load clears retract and fault
    load_req = 1; step(); load_req = 0;
    chk({stat_retract, stat_fault, door_unlock}, 3'b000, "R2 load clears retract and fault");

    // R7 ticks outside slew ignored, then coincidence
    tick_1ms = 1; repeat (50) step();
    drive_ready = 0; step(); drive_ready = 1;
    repeat (1666) step();
    chk(slew_rev, 1, "R7 loaded ticks not counted");
    carriage_back = 1; step();
    chk({slew_rev, servo_en, run_spindle, stat_fault}, 4'b0010, "R6 R7 carriage_back wins coincidence");
    tick_1ms = 0;

    // R8 stop needs carriage_back
    carriage_back = 0; stop_req = 1; step(); step();
    chk(run_spindle, 1, "R8 stop ignored without carriage_back");
    carriage_back = 1; step(); carriage_back = 0; stop_req = 0;
    chk(run_spindle, 0, "R8 stop with carriage_back");
    spindle_stopped = 1; step(); spindle_stopped = 0;

    // random phase
    for (int i = 0; i < 5000; i++) begin
      drive_ready     = ($urandom % 30) != 0;
      carriage_back   = ($urandom % 6) == 0;
      stop_req        = ($urandom % 3) == 0;
      spindle_stopped = ($urandom % 4) == 0;
      clear_status    = ($urandom % 8) == 0;
      tick_1ms        = $urandom % 2;
      load_req        = ($urandom % 5) == 0;
      cmd_req         = 3'($urandom);
      step();
    end
    summary();
  end
endmodule